// File: doc/BRIEF.md
# Broadcast Snoop Address-Phase Handshake

This block runs the address phase of a shared backplane bus that keeps caches coherent by snooping. A single master drives an address together with an address strobe. The address goes to every attached module, whether or not that module is the target. Each snooping module compares the address against its local tag directory. It holds back its release until that comparison finishes, and the master keeps the address on the bus until every module has released.

The release indication behaves as an active-low wired line. Here it is modelled as the AND of one release bit per snooper, and the phase completes only in a cycle where all of those bits are high. Each snooper has its own lookup latency, set through an input, and it reports hit or miss when it releases.

Once the phase completes, the master drops the strobe. It then waits for every snooper to return to idle before it accepts another request. Data transfer, arbitration and the coherence state transitions are outside this block.

Top module: `snoop_addr_phase`

## Requirements
- R1: While reset is active, bus_strobe is low, every bit of rel_bits is high, hit_vec is zero and req_ready is high.
- R2: A request is accepted in a cycle where req_valid and req_ready are both high. bus_strobe rises in the next cycle, with bus_addr equal to the accepted req_addr, and every snooper responds to it.
- R3: While bus_strobe is high, bus_addr stays unchanged from one cycle to the next.
- R4: addr_done is high exactly in the strobe cycle in which all rel_bits are high. With latencies L0..Ln-1, this is cycle 1+max(Li), counting the first strobe cycle as cycle 1.
- R5: Snooper i drives rel_bits[i] low from the first strobe cycle for exactly Li consecutive cycles, where Li is snoop_lat[i*LAT_W +: LAT_W]. A value of 0 is treated as 1.
- R6: When snooper i releases, it sets hit_vec[i] to dir_vld[i] AND (dir_tag[i*TAG_W +: TAG_W] == bus_addr[ADDR_W-1:OFS_W]). The bit is visible from the cycle after the capture edge and holds until the next capture.
- R7: bus_strobe is low in the cycle after addr_done.
- R8: req_ready stays low from the first strobe cycle through the two cycles after addr_done. It returns high in the third cycle after addr_done, once all snoopers are idle.
- R9: A req_valid that arrives while req_ready is low has no effect: bus_addr and bus_strobe keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Master wants to start an address phase |
| req_addr | input | ADDR_W | Address for the requested phase |
| req_ready | output | 1 | Sequencer and all snoopers idle; a request is accepted now |
| snoop_lat | input | N_SNOOP*LAT_W | Per-snooper lookup latency in cycles (0 means 1) |
| dir_tag | input | N_SNOOP*TAG_W | Per-snooper directory tag to compare |
| dir_vld | input | N_SNOOP | Per-snooper directory entry valid |
| bus_strobe | output | 1 | Address strobe |
| bus_addr | output | ADDR_W | Broadcast address |
| rel_bits | output | N_SNOOP | Per-snooper release bits (wired-AND inputs) |
| addr_done | output | 1 | Address phase completes this cycle |
| hit_vec | output | N_SNOOP | Per-snooper hit result |

## Verification
The bench uses mixed latencies, so that the slowest snooper alone has to hold the phase open. A design that ORed the releases instead of ANDing them would end early and fire addr_done on the fastest snooper. Latencies of 0 and 1 are checked for a one-cycle hold; an off-by-one counter would release a cycle late or never pull the line low. Requests are issued back to back, and stray requests are driven while a phase is open. A sequencer that restarted before the snoopers went idle, or that took a new address mid-phase, would raise req_ready early or change bus_addr under the strobe.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_ADDR  = 2'd1,
    MS_DRAIN = 2'd2
  } mseq_e;

  typedef enum logic [1:0] {
    SN_IDLE = 2'd0,
    SN_LOOK = 2'd1,
    SN_REL  = 2'd2
  } snp_e;
endpackage

// File: rtl/snp_master_seq.sv
module snp_master_seq
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              all_rel,
  input  logic              all_idle,
  output logic              req_ready,
  output logic              bus_strobe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              addr_done
);
  mseq_e st;
  logic  accept;

  // Named events for the checker and for readability
  assign req_ready  = (st == MS_IDLE) && all_idle;
  assign accept     = req_valid && req_ready;
  assign bus_strobe = (st == MS_ADDR);
  assign addr_done  = (st == MS_ADDR) && all_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= MS_IDLE;
      bus_addr <= '0;
    end else begin
      case (st)
        MS_IDLE: if (accept) begin
          st       <= MS_ADDR;
          bus_addr <= req_addr;
        end
        MS_ADDR:  if (all_rel)  st <= MS_DRAIN;
        MS_DRAIN: if (all_idle) st <= MS_IDLE;
        default:  st <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snp_responder.sv
module snp_responder
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 4,
  parameter int LAT_W  = 4,
  localparam int TAG_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_strobe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LAT_W-1:0]  lat,
  input  logic [TAG_W-1:0]  dir_tag,
  input  logic              dir_vld,
  output logic              rel,
  output logic              idle,
  output logic              hit
);
  localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

  // Latency of zero is treated as a single-cycle lookup
  function automatic logic [LAT_W-1:0] eff_lat(input logic [LAT_W-1:0] l);
    return (l == '0) ? ONE : l;
  endfunction

  function automatic logic tag_match(input logic [ADDR_W-1:0] a,
                                     input logic [TAG_W-1:0]  t,
                                     input logic              v);
    return v && (a[ADDR_W-1:OFS_W] == t);
  endfunction

  snp_e             st;
  logic [LAT_W-1:0] cnt;
  logic [LAT_W-1:0] lat_e;
  logic             look_end;

  assign lat_e    = eff_lat(lat);
  assign look_end = (st == SN_LOOK) && (cnt == ONE);
  assign idle     = (st == SN_IDLE);
  // Release is withheld from the first strobe cycle seen in idle
  assign rel      = (st == SN_REL) || ((st == SN_IDLE) && !bus_strobe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SN_IDLE;
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      case (st)
        SN_IDLE: if (bus_strobe) begin
          if (lat_e == ONE) begin
            st  <= SN_REL;
            hit <= tag_match(bus_addr, dir_tag, dir_vld);
          end else begin
            st  <= SN_LOOK;
            cnt <= lat_e - ONE;
          end
        end
        SN_LOOK: if (look_end) begin
          st  <= SN_REL;
          hit <= tag_match(bus_addr, dir_tag, dir_vld);
        end else begin
          cnt <= cnt - ONE;
        end
        SN_REL:  if (!bus_strobe) st <= SN_IDLE;
        default: st <= SN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snp_release_and.sv
module snp_release_and #(
  parameter int N_SNOOP = 4
) (
  input  logic [N_SNOOP-1:0] rel_bits,
  input  logic [N_SNOOP-1:0] idle_bits,
  output logic               all_rel,
  output logic               all_idle
);
  // Wired-AND of the active-low release line, modelled positively
  assign all_rel  = &rel_bits;
  assign all_idle = &idle_bits;
endmodule

// File: rtl/snoop_addr_phase.sv
module snoop_addr_phase #(
  parameter int ADDR_W  = 16,
  parameter int OFS_W   = 4,
  parameter int LAT_W   = 4,
  parameter int N_SNOOP = 4,
  localparam int TAG_W  = ADDR_W - OFS_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  output logic                     req_ready,
  input  logic [N_SNOOP*LAT_W-1:0] snoop_lat,
  input  logic [N_SNOOP*TAG_W-1:0] dir_tag,
  input  logic [N_SNOOP-1:0]       dir_vld,
  output logic                     bus_strobe,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [N_SNOOP-1:0]       rel_bits,
  output logic                     addr_done,
  output logic [N_SNOOP-1:0]       hit_vec
);
  logic [N_SNOOP-1:0] idle_bits;
  logic               all_rel;
  logic               all_idle;

  snp_master_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .all_rel    (all_rel),
    .all_idle   (all_idle),
    .req_ready  (req_ready),
    .bus_strobe (bus_strobe),
    .bus_addr   (bus_addr),
    .addr_done  (addr_done)
  );

  for (genvar i = 0; i < N_SNOOP; i++) begin : g_snp
    snp_responder #(
      .ADDR_W (ADDR_W),
      .OFS_W  (OFS_W),
      .LAT_W  (LAT_W)
    ) u_rsp (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_strobe (bus_strobe),
      .bus_addr   (bus_addr),
      .lat        (snoop_lat[i*LAT_W +: LAT_W]),
      .dir_tag    (dir_tag[i*TAG_W +: TAG_W]),
      .dir_vld    (dir_vld[i]),
      .rel        (rel_bits[i]),
      .idle       (idle_bits[i]),
      .hit        (hit_vec[i])
    );
  end

  snp_release_and #(.N_SNOOP(N_SNOOP)) u_and (
    .rel_bits  (rel_bits),
    .idle_bits (idle_bits),
    .all_rel   (all_rel),
    .all_idle  (all_idle)
  );
endmodule

// File: rtl/snoop_addr_phase_chk.sv
module snoop_addr_phase_chk #(
  parameter int ADDR_W  = 16,
  parameter int N_SNOOP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_strobe,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [N_SNOOP-1:0] rel_bits,
  input logic [N_SNOOP-1:0] idle_bits,
  input logic               addr_done,
  input logic               req_ready
);
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && $past(bus_strobe)) |-> $stable(bus_addr)); // R3

  AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_strobe) |-> (rel_bits == '0)); // R5

  AST_DONE_ALL_REL: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |-> (bus_strobe && (&rel_bits))); // R4

  AST_STROBE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |=> !bus_strobe); // R7

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_strobe) |-> $past(&idle_bits)); // R8

  AST_NO_READY_MID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |-> !req_ready); // R8

  AST_REL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |-> (&rel_bits)); // R5
endmodule

bind snoop_addr_phase snoop_addr_phase_chk #(
  .ADDR_W  (ADDR_W),
  .N_SNOOP (N_SNOOP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_strobe (bus_strobe),
  .bus_addr   (bus_addr),
  .rel_bits   (rel_bits),
  .idle_bits  (idle_bits),
  .addr_done  (addr_done),
  .req_ready  (req_ready)
);

// File: tb/snoop_addr_phase_bench.sv
module snoop_addr_phase_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int OW = 4;
  localparam int LW = 4;
  localparam int N  = 4;
  localparam int TW = AW - OW;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [AW-1:0]     req_addr;
  logic              req_ready;
  logic [N*LW-1:0]   snoop_lat;
  logic [N*TW-1:0]   dir_tag;
  logic [N-1:0]      dir_vld;
  logic              bus_strobe;
  logic [AW-1:0]     bus_addr;
  logic [N-1:0]      rel_bits;
  logic              addr_done;
  logic [N-1:0]      hit_vec;

  snoop_addr_phase #(.ADDR_W(AW), .OFS_W(OW), .LAT_W(LW), .N_SNOOP(N)) u_snoop_addr_phase (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .snoop_lat(snoop_lat), .dir_tag(dir_tag),
    .dir_vld(dir_vld), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
    .rel_bits(rel_bits), .addr_done(addr_done), .hit_vec(hit_vec)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Behavioural reference: phase 0 idle, 1 strobe, 2 drain
  int          m_phase;
  logic [AW-1:0] m_addr;
  int          busy_left[N];   // remaining hold cycles, -1 = not started
  bit          released[N];
  logic [N-1:0] m_hit;
  bit          accepted;
  bit          prev_done;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lat_of(int i);
    int v;
    v = int'(snoop_lat[i*LW +: LW]);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit hit_of(int i);
    return dir_vld[i] && (dir_tag[i*TW +: TW] == m_addr[AW-1:OW]);
  endfunction

  task automatic model_reset();
    m_phase = 0; m_addr = '0; m_hit = '0; prev_done = 0;
    for (int i = 0; i < N; i++) begin busy_left[i] = -1; released[i] = 0; end
  endtask

  // One clock: compare at negedge+1, then advance the model
  task automatic cycle();
    bit strobe_e, ready_e, done_e, idle_all;
    logic [N-1:0] rel_e;
    #1;
    strobe_e = (m_phase == 1);
    idle_all = 1;
    for (int i = 0; i < N; i++) begin
      if (busy_left[i] >= 0 || released[i]) idle_all = 0;
      if (busy_left[i] > 0) rel_e[i] = 1'b0;
      else if (released[i]) rel_e[i] = 1'b1;
      else rel_e[i] = !strobe_e;
    end
    ready_e = (m_phase == 0) && idle_all;
    done_e  = strobe_e && (&rel_e);
    chk("R2", "bus_strobe", 64'(bus_strobe), 64'(strobe_e));
    chk("R3", "bus_addr", 64'(bus_addr), 64'(m_addr));
    chk("R5", "rel_bits", 64'(rel_bits), 64'(rel_e));
    chk("R4", "addr_done", 64'(addr_done), 64'(done_e));
    chk("R8", "req_ready", 64'(req_ready), 64'(ready_e));
    chk("R6", "hit_vec", 64'(hit_vec), 64'(m_hit));
    if (prev_done) chk("R7", "strobe_after_done", 64'(bus_strobe), 64'(0));
    if (req_valid && !ready_e) chk("R9", "addr_while_busy", 64'(bus_addr), 64'(m_addr));
    // advance snoopers with the current strobe
    for (int i = 0; i < N; i++) begin
      if (released[i]) begin
        if (!strobe_e) released[i] = 0;
      end else if (busy_left[i] > 0) begin
        busy_left[i]--;
        if (busy_left[i] == 0) begin
          busy_left[i] = -1; released[i] = 1; m_hit[i] = hit_of(i);
        end
      end else if (strobe_e) begin
        busy_left[i] = lat_of(i) - 1;
        if (busy_left[i] == 0) begin
          busy_left[i] = -1; released[i] = 1; m_hit[i] = hit_of(i);
        end
      end
    end
    prev_done = done_e;
    case (m_phase)
      0: if (req_valid && ready_e) begin m_phase = 1; m_addr = req_addr; accepted = 1; end
      1: if (done_e) m_phase = 2;
      default: if (idle_all) m_phase = 0;
    endcase
    @(negedge clk);
  endtask

  task automatic run_txn(logic [AW-1:0] a, logic [N*LW-1:0] l,
                         logic [N*TW-1:0] t, logic [N-1:0] v, bit junk);
    snoop_lat = l; dir_tag = t; dir_vld = v;
    req_addr = a; req_valid = 1'b1; accepted = 0;
    for (int k = 0; k < 50 && !accepted; k++) cycle();
    if (junk) req_addr = ~a; else req_valid = 1'b0;
    for (int k = 0; k < 100 && m_phase != 0; k++) cycle();
    req_valid = 1'b0;
  endtask

  function automatic logic [N*TW-1:0] tags_for(logic [AW-1:0] a, logic [N-1:0] match);
    logic [N*TW-1:0] r;
    for (int i = 0; i < N; i++)
      r[i*TW +: TW] = match[i] ? a[AW-1:OW] : (a[AW-1:OW] ^ TW'(i + 1));
    return r;
  endfunction

  initial begin
    logic [31:0] seed;
    logic [AW-1:0] a;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    snoop_lat = '0; dir_tag = '0; dir_vld = '0;
    model_reset();
    @(negedge clk); @(negedge clk);
    #1;
    chk("R1", "reset_strobe", 64'(bus_strobe), 64'(0));
    chk("R1", "reset_rel", 64'(rel_bits), 64'({N{1'b1}}));
    chk("R1", "reset_ready", 64'(req_ready), 64'(1));
    chk("R1", "reset_hit", 64'(hit_vec), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    // all one-cycle lookups, two hits
    a = 16'h1230;
    run_txn(a, {4'd1, 4'd1, 4'd1, 4'd1}, tags_for(a, 4'b0101), 4'b1111, 0);
    // mixed latencies, stray requests while busy
    a = 16'hBEE0;
    run_txn(a, {4'd2, 4'd5, 4'd1, 4'd3}, tags_for(a, 4'b1010), 4'b1111, 1);
    // zero latency treated as one
    a = 16'h0040;
    run_txn(a, {4'd0, 4'd0, 4'd0, 4'd0}, tags_for(a, 4'b1111), 4'b0110, 0);
    // longest latency on one snooper
    a = 16'hFFF0;
    run_txn(a, {4'd1, 4'd7, 4'd2, 4'd15}, tags_for(a, 4'b1001), 4'b1011, 1);
    // gap of idle cycles then back-to-back traffic
    repeat (3) cycle();
    seed = 32'h1357_9BDF;
    for (int n = 0; n < 24; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      a = seed[31:16];
      run_txn(a, seed[15:0], tags_for(a, seed[19:16]), seed[23:20], seed[24]);
    end
    repeat (4) cycle();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule